// File: doc/BRIEF.md
# Floating-Point Sign and Word-Merge Unit

This unit carries out the register-to-register floating-point operations that need no arithmetic. They work on 64-bit double-precision register images and only move or change bits:

- copy a value unchanged;
- force its sign bit to clear or to set, or invert it;
- build a value from the sign of one operand and the magnitude of another;
- pair up the upper 32-bit words, or the lower 32-bit words, of two operands.

No operand is ever classified, so quiet and signalling NaNs pass through as ordinary bit patterns. No floating-point status is produced.

An issue stage presents one operation per cycle with `in_valid`. The operation comes with:

- the two operands;
- a record flag;
- the unit-enable bit;
- the current top nibble of the status register.

One cycle later the unit presents one of three outcomes:

- a registered result with a one-cycle write strobe;
- a write strobe for condition field 1, together with its value, in addition to the result write;
- an unavailable-unit exception, which blocks every write.

A small state machine holds the outcome class. Its states are:

- **ST_IDLE**: nothing issued.
- **ST_WRITE**: the result is being written.
- **ST_TRAP**: the exception is raised.

Its transitions are:

- **GO_WRITE**: taken on a valid, enabled, legal operation.
- **GO_TRAP**: taken on a valid operation while the unit is disabled.
- **GO_IDLE**: taken when nothing is issued, or when the operation code is reserved.

Each transition can be taken from any state, so back-to-back issue is allowed.

Top module: `fp_sign_merge_unit`

## Requirements
- R1: While reset is held, and on the first cycle after it is released, `res_we`, `cf1_we` and `unavail_exc` are 0, and `res_data` and `cf1_val` are 0.
- R2: Operation codes 0, 1, 2 and 3 are move, absolute, negative-absolute and negate. The result is B, with bit 63 left as it is, cleared, set or inverted respectively. Bits 62..0 are copied from B.
- R3: Operation code 4 (copy-sign) gives bit 63 of A above bits 62..0 of B.
- R4: Operation code 5 (upper-word merge) gives {A[63:32], B[63:32]}.
- R5: Operation code 6 (lower-word merge) gives {A[31:0], B[31:0]}.
- R6: An accepted operation raises `res_wr` for exactly the cycle after the one in which `in_valid` was sampled high, with `res_data` valid in that cycle. Operations issued on consecutive cycles produce consecutive write pulses.
- R7: A valid input with `unit_en` low raises `unavail_exc` for the next cycle, whatever the operation code. In that cycle `res_we` and `cf1_we` stay 0, and `res_data` and `cf1_val` keep their previous values.
- R8: For codes 0 to 4 with the record flag set, `cf1_we` is high in the same cycle as `res_we`, and `cf1_val` equals the `status_top` sampled with the operation.
- R9: The merge codes 5 and 6 never raise `cf1_we`, even when the record flag is set, and `cf1_val` keeps its value.
- R10: Operands that encode NaNs (for example signalling NaN 0x7FF0000000000001) are not treated specially. The result follows R2 to R5 bit for bit.
- R11: Operation code 7 is reserved. With the unit enabled it causes no write, no condition-field update and no exception, and `res_data` keeps its value.
- R12: With the record flag clear, `cf1_we` stays 0 for every operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | An operation is presented this cycle |
| op_sel | input | 3 | Operation code (see R2 to R5, R11) |
| rec_flag | input | 1 | Request a condition field 1 update |
| unit_en | input | 1 | Floating-point unit enabled |
| status_top | input | 4 | Top nibble of the status register |
| opnd_a | input | 64 | Operand A |
| opnd_b | input | 64 | Operand B |
| res_data | output | 64 | Registered result |
| res_we | output | 1 | Destination write strobe |
| cf1_we | output | 1 | Condition field 1 write strobe |
| cf1_val | output | 4 | Value for condition field 1 |
| unavail_exc | output | 1 | Unavailable-unit exception |

## Verification
Two pairs of outcomes can fall in the same cycle, and both are exercised.

- **Result write with condition-field write.** A sign operation or move issued with the record flag set writes the result and condition field 1 in the same cycle. The bench drives each such code with a changing `status_top` and compares both strobes and both values together.
- **Exception with write.** The exception and the write compete for the same cycle. The bench issues operations with the unit disabled, both alone and between enabled operations. It checks that the exception appears and that no strobe fires, and that `res_data` and `cf1_val` keep the values written before.

The reference model compares every cycle, including idle cycles and cycles with reserved codes.

// File: rtl/fpsm_pkg.sv
package fpsm_pkg;

    typedef enum logic [2:0] {
        OP_MOVE    = 3'd0,
        OP_ABS     = 3'd1,
        OP_NABS    = 3'd2,
        OP_NEG     = 3'd3,
        OP_CPSGN   = 3'd4,
        OP_MRG_HI  = 3'd5,
        OP_MRG_LO  = 3'd6,
        OP_RSVD    = 3'd7
    } fpsm_op_e;

    typedef enum logic [2:0] {
        SGN_KEEP,
        SGN_CLR,
        SGN_SET,
        SGN_FLIP,
        SGN_FROM_A
    } sign_act_e;

    typedef enum logic [1:0] {
        SRC_SIGNED,
        SRC_HI_PAIR,
        SRC_LO_PAIR
    } src_sel_e;

    typedef struct packed {
        logic      legal;
        logic      rec_ok;
        src_sel_e  src;
        sign_act_e sact;
    } fpsm_ctl_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WRITE,
        ST_TRAP
    } fpsm_state_e;

endpackage

// File: rtl/fpsm_decode.sv
module fpsm_decode
    import fpsm_pkg::*;
(
    input  logic [2:0] op_sel,
    output fpsm_ctl_t  ctl
);
    always_comb begin
        ctl.legal  = 1'b1;
        ctl.rec_ok = 1'b1;
        ctl.src    = SRC_SIGNED;
        ctl.sact   = SGN_KEEP;
        unique case (fpsm_op_e'(op_sel))
            OP_MOVE:   ctl.sact = SGN_KEEP;
            OP_ABS:    ctl.sact = SGN_CLR;
            OP_NABS:   ctl.sact = SGN_SET;
            OP_NEG:    ctl.sact = SGN_FLIP;
            OP_CPSGN:  ctl.sact = SGN_FROM_A;
            OP_MRG_HI: begin
                ctl.src    = SRC_HI_PAIR;
                ctl.rec_ok = 1'b0;
            end
            OP_MRG_LO: begin
                ctl.src    = SRC_LO_PAIR;
                ctl.rec_ok = 1'b0;
            end
            OP_RSVD: begin
                ctl.legal  = 1'b0;
                ctl.rec_ok = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/fpsm_datapath.sv
module fpsm_datapath
    import fpsm_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  src_sel_e            src,
    input  sign_act_e           sact,
    input  logic [DATA_W-1:0]   opnd_a,
    input  logic [DATA_W-1:0]   opnd_b,
    output logic [DATA_W-1:0]   result
);
    localparam int HALF_W = DATA_W / 2;
    localparam int SGN    = DATA_W - 1;

    logic              new_sign;
    logic [DATA_W-1:0] signed_val;
    logic [DATA_W-1:0] hi_pair;
    logic [DATA_W-1:0] lo_pair;

    always_comb begin
        new_sign = opnd_b[SGN];
        unique case (sact)
            SGN_KEEP:   new_sign = opnd_b[SGN];
            SGN_CLR:    new_sign = 1'b0;
            SGN_SET:    new_sign = 1'b1;
            SGN_FLIP:   new_sign = ~opnd_b[SGN];
            SGN_FROM_A: new_sign = opnd_a[SGN];
            default:    new_sign = opnd_b[SGN];
        endcase
    end

    assign signed_val = {new_sign, opnd_b[SGN-1:0]};

    // Word pairing: one generate loop builds both merge variants.
    for (genvar w = 0; w < 2; w++) begin : g_pair
        localparam int LO_BIT = w * HALF_W;
        localparam int HI_BIT = LO_BIT + HALF_W - 1;
        if (w == 0) begin : g_lo
            assign lo_pair[DATA_W-1:HALF_W] = opnd_a[HI_BIT:LO_BIT];
            assign lo_pair[HALF_W-1:0]      = opnd_b[HI_BIT:LO_BIT];
        end else begin : g_hi
            assign hi_pair[DATA_W-1:HALF_W] = opnd_a[HI_BIT:LO_BIT];
            assign hi_pair[HALF_W-1:0]      = opnd_b[HI_BIT:LO_BIT];
        end
    end

    always_comb begin
        unique case (src)
            SRC_HI_PAIR: result = hi_pair;
            SRC_LO_PAIR: result = lo_pair;
            default:     result = signed_val;
        endcase
    end
endmodule

// File: rtl/fpsm_seq.sv
module fpsm_seq
    import fpsm_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int STAT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              unit_en,
    input  logic              legal,
    input  logic              rec_ok,
    input  logic              rec_flag,
    input  logic [STAT_W-1:0] status_top,
    input  logic [DATA_W-1:0] next_res,
    output logic [DATA_W-1:0] res_data,
    output logic              res_we,
    output logic              cf1_we,
    output logic [STAT_W-1:0] cf1_val,
    output logic              unavail_exc
);
    fpsm_state_e       state_q, state_d;
    logic              cf_pend_q;
    logic [DATA_W-1:0] res_q;
    logic [STAT_W-1:0] cf_q;
    logic              take_cf;

    // Transitions GO_TRAP, GO_WRITE, GO_IDLE; the exception wins over the write.
    always_comb begin
        state_d = ST_IDLE;
        if (in_valid && !unit_en)
            state_d = ST_TRAP;
        else if (in_valid && legal)
            state_d = ST_WRITE;
    end

    assign take_cf = (state_d == ST_WRITE) && rec_ok && rec_flag;

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Payload registers, loaded only on the write path.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q     <= '0;
            cf_q      <= '0;
            cf_pend_q <= 1'b0;
        end else begin
            cf_pend_q <= take_cf;
            if (state_d == ST_WRITE) res_q <= next_res;
            if (take_cf)             cf_q  <= status_top;
        end
    end

    // Outputs decoded from the state.
    always_comb begin
        res_we      = 1'b0;
        cf1_we      = 1'b0;
        unavail_exc = 1'b0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_WRITE: begin
                res_we = 1'b1;
                cf1_we = cf_pend_q;
            end
            ST_TRAP:  unavail_exc = 1'b1;
            default:  ;
        endcase
    end

    assign res_data = res_q;
    assign cf1_val  = cf_q;
endmodule

// File: rtl/fp_sign_merge_unit.sv
module fp_sign_merge_unit
    import fpsm_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int STAT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [2:0]        op_sel,
    input  logic              rec_flag,
    input  logic              unit_en,
    input  logic [STAT_W-1:0] status_top,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    output logic [DATA_W-1:0] res_data,
    output logic              res_we,
    output logic              cf1_we,
    output logic [STAT_W-1:0] cf1_val,
    output logic              unavail_exc
);
    fpsm_ctl_t         ctl;
    logic [DATA_W-1:0] next_res;

    fpsm_decode u_dec (
        .op_sel (op_sel),
        .ctl    (ctl)
    );

    fpsm_datapath #(.DATA_W(DATA_W)) u_dp (
        .src    (ctl.src),
        .sact   (ctl.sact),
        .opnd_a (opnd_a),
        .opnd_b (opnd_b),
        .result (next_res)
    );

    fpsm_seq #(.DATA_W(DATA_W), .STAT_W(STAT_W)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .unit_en     (unit_en),
        .legal       (ctl.legal),
        .rec_ok      (ctl.rec_ok),
        .rec_flag    (rec_flag),
        .status_top  (status_top),
        .next_res    (next_res),
        .res_data    (res_data),
        .res_we      (res_we),
        .cf1_we      (cf1_we),
        .cf1_val     (cf1_val),
        .unavail_exc (unavail_exc)
    );
endmodule

// File: rtl/fp_sign_merge_unit_chk.sv
module fp_sign_merge_unit_chk #(
    parameter int DATA_W = 64,
    parameter int STAT_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [2:0]        op_sel,
    input logic              rec_flag,
    input logic              unit_en,
    input logic [STAT_W-1:0] status_top,
    input logic [DATA_W-1:0] opnd_a,
    input logic [DATA_W-1:0] opnd_b,
    input logic [DATA_W-1:0] res_data,
    input logic              res_we,
    input logic              cf1_we,
    input logic [STAT_W-1:0] cf1_val,
    input logic              unavail_exc
);
    localparam int HALF_W = DATA_W / 2;
    localparam int SGN    = DATA_W - 1;

    // R7
    exc_blocks_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && !unit_en |=> unavail_exc && !res_we && !cf1_we);

    // R7
    exc_holds_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        unavail_exc |-> $stable(res_data) && $stable(cf1_val));

    // R8
    cf_only_with_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cf1_we |-> res_we);

    // R8
    cf_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && unit_en && rec_flag && op_sel <= 3'd4
        |=> cf1_we && cf1_val == $past(status_top));

    // R9
    merge_no_cf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && unit_en && (op_sel == 3'd5 || op_sel == 3'd6) |=> !cf1_we);

    // R2
    abs_clears_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && unit_en && op_sel == 3'd1
        |=> res_we && !res_data[SGN] && res_data[SGN-1:0] == $past(opnd_b[SGN-1:0]));

    // R4
    hi_merge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && unit_en && op_sel == 3'd5
        |=> res_data == {$past(opnd_a[DATA_W-1:HALF_W]), $past(opnd_b[DATA_W-1:HALF_W])});

    // R5
    lo_merge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && unit_en && op_sel == 3'd6
        |=> res_data == {$past(opnd_a[HALF_W-1:0]), $past(opnd_b[HALF_W-1:0])});

    // R11
    rsvd_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && unit_en && op_sel == 3'd7 |=> !res_we && !unavail_exc && !cf1_we);

    // R6
    write_needs_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !res_we && !unavail_exc);
endmodule

bind fp_sign_merge_unit fp_sign_merge_unit_chk #(.DATA_W(DATA_W), .STAT_W(STAT_W)) u_chk (.*);

// File: tb/fp_sign_merge_unit_test.sv
`timescale 1ns/1ps
module fp_sign_merge_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [2:0]  op_sel = '0;
    logic        rec_flag = 1'b0;
    logic        unit_en = 1'b1;
    logic [3:0]  status_top = '0;
    logic [63:0] opnd_a = '0;
    logic [63:0] opnd_b = '0;
    logic [63:0] res_data;
    logic        res_we, cf1_we, unavail_exc;
    logic [3:0]  cf1_val;

    int n_chk = 0;
    int n_bad = 0;
    bit cmp_on = 1'b0;

    // Reference model state
    logic [63:0] m_res = '0;
    logic        m_we = 1'b0, m_cfwe = 1'b0, m_exc = 1'b0;
    logic [3:0]  m_cf = '0;
    string       m_tag = "R1";

    always #2.5 clk = ~clk;

    fp_sign_merge_unit uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel),
        .rec_flag(rec_flag), .unit_en(unit_en), .status_top(status_top),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .res_data(res_data), .res_we(res_we),
        .cf1_we(cf1_we), .cf1_val(cf1_val), .unavail_exc(unavail_exc)
    );

    function automatic logic [63:0] model_op(input int op, input logic [63:0] a, input logic [63:0] b);
        logic [63:0] mag;
        mag = b & 64'h7FFF_FFFF_FFFF_FFFF;
        case (op)
            0: return b;
            1: return mag;
            2: return mag | 64'h8000_0000_0000_0000;
            3: return b ^ 64'h8000_0000_0000_0000;
            4: return mag | (a & 64'h8000_0000_0000_0000);
            5: return (a & 64'hFFFF_FFFF_0000_0000) | (b >> 32);
            6: return (a << 32) | (b & 64'h0000_0000_FFFF_FFFF);
            default: return 64'h0;
        endcase
    endfunction

    function automatic string tag_for(input int op, input bit rec);
        if (op <= 3)     return rec ? "R2/R8" : "R2/R12";
        else if (op == 4) return rec ? "R3/R8" : "R3/R12";
        else if (op == 5) return rec ? "R4/R9" : "R4";
        else if (op == 6) return rec ? "R5/R9" : "R5";
        return "R11";
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_res = '0; m_we = 0; m_cfwe = 0; m_exc = 0; m_cf = '0; m_tag = "R1";
        end else begin
            m_we = 0; m_cfwe = 0; m_exc = 0; m_tag = "R6";
            if (in_valid) begin
                if (!unit_en) begin
                    m_exc = 1; m_tag = "R7";
                end else if (op_sel != 3'd7) begin
                    m_we  = 1;
                    m_res = model_op(int'(op_sel), opnd_a, opnd_b);
                    m_tag = tag_for(int'(op_sel), rec_flag);
                    if (rec_flag && op_sel <= 3'd4) begin
                        m_cfwe = 1; m_cf = status_top;
                    end
                end else begin
                    m_tag = "R11";
                end
            end
        end
    end

    always @(negedge clk) begin
        if (cmp_on) begin
            n_chk++;
            if (res_data !== m_res || res_we !== m_we || cf1_we !== m_cfwe ||
                cf1_val !== m_cf || unavail_exc !== m_exc) begin
                n_bad++;
                $display("FAIL %s: got res=%h we=%b cfwe=%b cf=%h exc=%b exp res=%h we=%b cfwe=%b cf=%h exc=%b",
                         m_tag, res_data, res_we, cf1_we, cf1_val, unavail_exc,
                         m_res, m_we, m_cfwe, m_cf, m_exc);
            end
        end
    end

    task automatic issue(input int op, input logic [63:0] a, input logic [63:0] b,
                         input bit rec, input bit en, input logic [3:0] st);
        @(negedge clk); #1;
        in_valid = 1; op_sel = op[2:0]; opnd_a = a; opnd_b = b;
        rec_flag = rec; unit_en = en; status_top = st;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); #1;
            in_valid = 0; op_sel = 3'd7; unit_en = 1;
        end
    endtask

    task automatic finish_run;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        #50000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: got hung run, expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state while reset is held
        n_chk++;
        if (res_data !== 0 || res_we !== 0 || cf1_we !== 0 || cf1_val !== 0 || unavail_exc !== 0) begin
            n_bad++;
            $display("FAIL R1: got res=%h we=%b cfwe=%b exc=%b, expected all zero",
                     res_data, res_we, cf1_we, unavail_exc);
        end
        #1 rst_n = 1;
        cmp_on = 1;
        idle(2);
        // R2/R8: sign ops and move with record flag, varying status
        for (int op = 0; op < 4; op++)
            issue(op, 64'h0, 64'hC00F_1234_5678_9ABC ^ (64'(op) << 8), 1, 1, 4'(op + 9));
        for (int op = 0; op < 4; op++)
            issue(op, 64'h0, 64'h3FF0_0000_0000_0001 + 64'(op), 0, 1, 4'hF);
        // R3: copy-sign both sign combinations
        issue(4, 64'h8000_0000_0000_0000, 64'h4000_0000_0000_0000, 1, 1, 4'h5);
        issue(4, 64'h7FFF_FFFF_FFFF_FFFF, 64'hC123_4567_89AB_CDEF, 0, 1, 4'h6);
        // R4/R5/R9: merges, record flag set
        issue(5, 64'h1111_2222_3333_4444, 64'h5555_6666_7777_8888, 1, 1, 4'hA);
        issue(6, 64'h1111_2222_3333_4444, 64'h5555_6666_7777_8888, 1, 1, 4'hB);
        idle(1);
        // R10: signalling NaN inputs
        issue(3, 64'h0, 64'h7FF0_0000_0000_0001, 0, 1, 4'h0);
        issue(1, 64'h0, 64'hFFF0_0000_0000_0001, 0, 1, 4'h0);
        issue(4, 64'hFFF8_0000_0000_0000, 64'h7FF0_0000_0000_0001, 0, 1, 4'h0);
        // R7: disabled unit between enabled ops, all codes
        for (int op = 0; op < 8; op++) begin
            issue(op, 64'hDEAD_BEEF_0000_0001, 64'hCAFE_F00D_1234_5678, 1, 0, 4'h3);
            issue(2, 64'h0, 64'h0123_4567_89AB_CDEF + 64'(op), 1, 1, 4'(op));
            issue(op, 64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 1, 0, 4'hC);
            idle(1);
        end
        // R11: reserved code with record
        issue(7, 64'h1, 64'h2, 1, 1, 4'h9);
        idle(2);
        // R6: back-to-back pattern sweep
        for (int i = 0; i < 40; i++)
            issue(i % 7, {32'(i * 7919), 32'(i * 104729)}, {32'(~i), 32'(i * 31)}, i[0], 1, 4'(i));
        idle(3);
        cmp_on = 0;
        finish_run();
    end
endmodule